// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences a processor between three operating modes: run (normal operation), idle (core clock stopped, all logic still powered) and sleep (most of the chip switched off). Software asks for idle or sleep through a one-cycle request. An enabled interrupt brings the core back from idle, and a wake event brings it back from sleep. Every transition costs time. Each delay is a parameter counted in cycles of an always-on reference clock, and one shared down-counter times them.

Sleep can be entered only from run. Entry is a fixed sequence of steps, one per power domain. Each step switches off one more domain in ascending index order, so the domains are turned off cumulatively. Leaving sleep switches the domains back on in descending order, one release step each. A long settle wait follows, and the core clock restarts only after it. The mode output keeps the mode the controller is leaving until the target is reached, and the busy flag is high for the whole transition. A per-mode power estimate is driven in units of 10 µW.

States: `ST_RUN`, `ST_IDLE_ENTER`, `ST_IDLE`, `ST_IDLE_EXIT`, `ST_SLEEP_ENTER`, `ST_SLEEP`, `ST_WAKE_RELEASE`, `ST_WAKE_SETTLE`. Transitions:
- run→idle-enter on an idle request
- idle-enter→idle when the timer expires
- idle→idle-exit on an interrupt
- idle-exit→run when the timer expires
- run→sleep-enter on a sleep request
- sleep-enter repeats once per domain, then →sleep
- sleep→wake-release on a wake event
- wake-release repeats once per domain, then →wake-settle
- wake-settle→run when the timer expires

Top module: `pm_ctrl`

## Requirements
- R1: After reset the controller is in run: mode 0, busy 0, core clock enable 1, every power-off enable 0.
- R2: A request with `req_mode`=1 (idle) accepted in settled run gives `T_IDLE_IN` cycles of busy=1 with mode still 0 and the clock enabled. Then the controller settles in idle: mode 1, busy 0, clock enable 0, no domain off.
- R3: In settled idle, `irq_wake`=1 gives `T_IDLE_OUT` cycles of busy=1, mode 1 and clock off. Then the controller settles in run with the clock enabled.
- R4: A request with `req_mode`=2 (sleep) in settled run drops the clock enable at once and runs `N_DOM` steps of `T_STEP` cycles each. During step k, `pwr_off` bits 0..k are 1 and mode stays 0. Then the controller settles in sleep: mode 2, busy 0, all `pwr_off` bits 1.
- R5: In settled sleep, `wake_evt`=1 starts `N_DOM` release steps of `T_RLS` cycles each. During release step j (counting down from `N_DOM`-1 to 0), only bits below j are 1. Then come `T_WAKE` cycles with every domain on and the clock still off. Then the controller settles in run.
- R6: A sleep request is ignored in idle. Sleep is reachable only from run.
- R7: A request arriving while busy is ignored. Busy stays high until the target mode is reached, and mode changes only in the cycle busy falls.
- R8: `irq_wake` has no effect in run or sleep, and `wake_evt` has no effect in run or idle.
- R9: `power_est` is 40000 for mode 0, 5000 for mode 1 and 16 for mode 2, in units of 10 µW.
- R10: Request codes 0 and 3 are ignored in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 2 | Requested mode: 1 idle, 2 sleep |
| irq_wake | input | 1 | Enabled interrupt pending (leaves idle) |
| wake_evt | input | 1 | Wake event (leaves sleep) |
| mode_o | output | 2 | Current mode: 0 run, 1 idle, 2 sleep |
| busy | output | 1 | Transition in progress |
| core_clk_en | output | 1 | Enable for the core clock gate |
| pwr_off | output | N_DOM | Power-switch off enables, one per domain |
| power_est | output | 16 | Estimated power in 10 µW units |

## Verification
A request, interrupt or wake strobe is captured on the clock edge that samples it. All outputs are decoded straight from the state register, so the first transition value appears on that same edge. Each timed phase then lasts exactly its parameter in cycles, so a timed state holds for N cycles from the edge that loads its timer. For every stimulus, the bench queues one expected output set per cycle, starting with the cycle after the capturing edge. A monitor compares one queued set at each falling edge. Stimuli that must be ignored are followed by queued settled values, so any effect they had would show up at the ports.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_SLEEP = 2'd2
    } pm_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE_ENTER,
        ST_IDLE,
        ST_IDLE_EXIT,
        ST_SLEEP_ENTER,
        ST_SLEEP,
        ST_WAKE_RELEASE,
        ST_WAKE_SETTLE
    } pm_state_e;

    localparam int unsigned EST_W = 16;
    // power estimates in 10 uW units
    localparam logic [EST_W-1:0] EST_RUN   = 16'd40000;
    localparam logic [EST_W-1:0] EST_IDLE  = 16'd5000;
    localparam logic [EST_W-1:0] EST_SLEEP = 16'd16;

endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R2: an expired timer stays expired until reloaded
    p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import pm_pkg::*;
#(
    parameter int unsigned W          = 8,
    parameter int unsigned N_DOM      = 3,
    parameter int unsigned T_IDLE_IN  = 10,
    parameter int unsigned T_IDLE_OUT = 10,
    parameter int unsigned T_STEP     = 30,
    parameter int unsigned T_RLS      = 10,
    parameter int unsigned T_WAKE     = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_mode,
    input  logic             irq_wake,
    input  logic             wake_evt,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [W-1:0]     tmr_val,
    output pm_mode_e         mode_o,
    output logic             busy,
    output logic             core_clk_en,
    output logic [N_DOM-1:0] pwr_off
);
    localparam int unsigned SW = (N_DOM > 1) ? $clog2(N_DOM) : 1;
    localparam logic [SW-1:0] LAST_STEP = SW'(N_DOM - 1);
    localparam logic [W-1:0]  LD_IDLE_IN  = W'(T_IDLE_IN - 1);
    localparam logic [W-1:0]  LD_IDLE_OUT = W'(T_IDLE_OUT - 1);
    localparam logic [W-1:0]  LD_STEP     = W'(T_STEP - 1);
    localparam logic [W-1:0]  LD_RLS      = W'(T_RLS - 1);
    localparam logic [W-1:0]  LD_WAKE     = W'(T_WAKE - 1);

    pm_state_e     state, nxt_state;
    logic [SW-1:0] step, nxt_step;

    wire want_idle  = req_valid && (req_mode == 2'd1);
    wire want_sleep = req_valid && (req_mode == 2'd2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            step  <= '0;
        end else begin
            state <= nxt_state;
            step  <= nxt_step;
        end
    end

    // next state and timer loads
    always_comb begin
        nxt_state = state;
        nxt_step  = step;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state)
            ST_RUN: begin
                if (want_idle) begin
                    nxt_state = ST_IDLE_ENTER;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_IDLE_IN;
                end else if (want_sleep) begin
                    nxt_state = ST_SLEEP_ENTER;
                    nxt_step  = '0;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_STEP;
                end
            end
            ST_IDLE_ENTER: begin
                if (tmr_expired) nxt_state = ST_IDLE;
            end
            ST_IDLE: begin
                if (irq_wake) begin
                    nxt_state = ST_IDLE_EXIT;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_IDLE_OUT;
                end
            end
            ST_IDLE_EXIT: begin
                if (tmr_expired) nxt_state = ST_RUN;
            end
            ST_SLEEP_ENTER: begin
                if (tmr_expired) begin
                    if (step == LAST_STEP) begin
                        nxt_state = ST_SLEEP;
                    end else begin
                        nxt_step = step + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_STEP;
                    end
                end
            end
            ST_SLEEP: begin
                if (wake_evt) begin
                    nxt_state = ST_WAKE_RELEASE;
                    nxt_step  = LAST_STEP;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_RLS;
                end
            end
            ST_WAKE_RELEASE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (step == '0) begin
                        nxt_state = ST_WAKE_SETTLE;
                        tmr_val   = LD_WAKE;
                    end else begin
                        nxt_step = step - 1'b1;
                        tmr_val  = LD_RLS;
                    end
                end
            end
            ST_WAKE_SETTLE: begin
                if (tmr_expired) nxt_state = ST_RUN;
            end
            default: nxt_state = ST_RUN;
        endcase
    end

    // mode, busy and clock enable outputs
    always_comb begin
        mode_o      = MODE_RUN;
        busy        = 1'b1;
        core_clk_en = 1'b0;
        unique case (state)
            ST_RUN:          begin busy = 1'b0; core_clk_en = 1'b1; end
            ST_IDLE_ENTER:   core_clk_en = 1'b1;
            ST_IDLE:         begin mode_o = MODE_IDLE; busy = 1'b0; end
            ST_IDLE_EXIT:    mode_o = MODE_IDLE;
            ST_SLEEP_ENTER:  mode_o = MODE_RUN;
            ST_SLEEP:        begin mode_o = MODE_SLEEP; busy = 1'b0; end
            ST_WAKE_RELEASE: mode_o = MODE_SLEEP;
            ST_WAKE_SETTLE:  mode_o = MODE_SLEEP;
            default:         mode_o = MODE_RUN;
        endcase
    end

    // per-domain power-off enables: ascending on entry, descending on release
    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        if (d == 0) begin : g_first
            assign pwr_off[d] = (state == ST_SLEEP) || (state == ST_SLEEP_ENTER)
                             || ((state == ST_WAKE_RELEASE) && (step != '0));
        end else begin : g_rest
            assign pwr_off[d] = (state == ST_SLEEP)
                             || ((state == ST_SLEEP_ENTER) && (step >= SW'(d)))
                             || ((state == ST_WAKE_RELEASE) && (step > SW'(d)));
        end
    end

    // R1: settled run has the clock on and every domain powered
    p_run_powered_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RUN && !busy) |-> (core_clk_en && pwr_off == '0));

    // R3: idle keeps logic powered with the clock stopped
    p_idle_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_IDLE) |-> (!core_clk_en && pwr_off == '0));

    // R4: settled sleep has all domains off and the clock stopped
    p_sleep_all_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && !busy) |-> (!core_clk_en && pwr_off == '1));

    // R4: during entry domains are only ever added
    p_entry_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP_ENTER) |=> ((pwr_off & $past(pwr_off)) == $past(pwr_off)));

    // R5: during release domains are only ever removed
    p_release_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE_RELEASE) |=> ((pwr_off | $past(pwr_off)) == $past(pwr_off)));

    // R5: the core clock restarts only with all domains back on, in run
    p_clk_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (pwr_off == '0 && mode_o == MODE_RUN));

    // R7: mode changes only when a transition completes
    p_mode_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != $past(mode_o)) |-> ($past(busy) && !busy));

endmodule

// File: rtl/pm_power_est.sv
module pm_power_est
    import pm_pkg::*;
(
    input  pm_mode_e         mode,
    output logic [EST_W-1:0] est
);
    always_comb begin
        unique case (mode)
            MODE_RUN:   est = EST_RUN;
            MODE_IDLE:  est = EST_IDLE;
            MODE_SLEEP: est = EST_SLEEP;
            default:    est = EST_RUN;
        endcase
    end
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
    import pm_pkg::*;
#(
    parameter int unsigned N_DOM      = 3,
    parameter int unsigned T_IDLE_IN  = 10,
    parameter int unsigned T_IDLE_OUT = 10,
    parameter int unsigned T_STEP     = 30,
    parameter int unsigned T_RLS      = 10,
    parameter int unsigned T_WAKE     = 160000
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_mode,
    input  logic             irq_wake,
    input  logic             wake_evt,
    output logic [1:0]       mode_o,
    output logic             busy,
    output logic             core_clk_en,
    output logic [N_DOM-1:0] pwr_off,
    output logic [15:0]      power_est
);
    localparam int unsigned M1 = (T_IDLE_IN > T_IDLE_OUT) ? T_IDLE_IN : T_IDLE_OUT;
    localparam int unsigned M2 = (T_STEP > T_RLS) ? T_STEP : T_RLS;
    localparam int unsigned M3 = (M1 > M2) ? M1 : M2;
    localparam int unsigned TMAX = (M3 > T_WAKE) ? M3 : T_WAKE;
    localparam int unsigned W = $clog2(TMAX + 1);

    logic         tmr_load;
    logic [W-1:0] tmr_val;
    logic         tmr_expired;
    pm_mode_e     mode_q;

    pm_timer #(.W(W)) u_timer (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pm_fsm #(
        .W(W), .N_DOM(N_DOM), .T_IDLE_IN(T_IDLE_IN), .T_IDLE_OUT(T_IDLE_OUT),
        .T_STEP(T_STEP), .T_RLS(T_RLS), .T_WAKE(T_WAKE)
    ) u_fsm (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_mode    (req_mode),
        .irq_wake    (irq_wake),
        .wake_evt    (wake_evt),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .mode_o      (mode_q),
        .busy        (busy),
        .core_clk_en (core_clk_en),
        .pwr_off     (pwr_off)
    );

    pm_power_est u_est (
        .mode (mode_q),
        .est  (power_est)
    );

    assign mode_o = mode_q;

endmodule

// File: tb/test_pm_ctrl.sv
`timescale 1ns/1ps
module test_pm_ctrl;
    localparam int TI_IN = 4, TI_OUT = 3, TSTEP = 5, TRLS = 2, TWAKE = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, irq_wake = 1'b0, wake_evt = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic [1:0] mode_o;
    logic busy, core_clk_en;
    logic [2:0] pwr_off;
    logic [15:0] power_est;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [1:0] mode;
        logic       busy;
        logic       clk;
        logic [2:0] off;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    pm_ctrl #(.N_DOM(3), .T_IDLE_IN(TI_IN), .T_IDLE_OUT(TI_OUT),
              .T_STEP(TSTEP), .T_RLS(TRLS), .T_WAKE(TWAKE)) i_pm_ctrl (
        .clk_ref(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .irq_wake(irq_wake), .wake_evt(wake_evt), .mode_o(mode_o), .busy(busy),
        .core_clk_en(core_clk_en), .pwr_off(pwr_off), .power_est(power_est)
    );

    // R9: expected estimate per mode
    function automatic logic [15:0] est_of(input logic [1:0] m);
        case (m)
            2'd0:    return 16'd40000;
            2'd1:    return 16'd5000;
            default: return 16'd16;
        endcase
    endfunction

    task automatic push_n(input string tag, input logic [1:0] m, input logic b,
                          input logic c, input logic [2:0] o, input int n);
        exp_t e;
        e.tag = tag; e.mode = m; e.busy = b; e.clk = c; e.off = o;
        for (int i = 0; i < n; i++) sb_q.push_back(e);
    endtask

    // kind 0: request, 1: interrupt, 2: wake event
    task automatic pulse(input int kind, input logic [1:0] m);
        @(posedge clk); #1;
        case (kind)
            0: begin req_valid = 1'b1; req_mode = m; end
            1: irq_wake = 1'b1;
            default: wake_evt = 1'b1;
        endcase
        @(posedge clk); #1;
        req_valid = 1'b0; req_mode = 2'd0; irq_wake = 1'b0; wake_evt = 1'b0;
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        @(posedge clk);
    endtask

    // monitor: one expected item per falling edge
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (mode_o !== e.mode || busy !== e.busy || core_clk_en !== e.clk ||
                pwr_off !== e.off || power_est !== est_of(e.mode)) begin
                errors++;
                $display("FAIL %s: got mode=%0d busy=%0b clk=%0b off=%b est=%0d exp mode=%0d busy=%0b clk=%0b off=%b est=%0d",
                         e.tag, mode_o, busy, core_clk_en, pwr_off, power_est,
                         e.mode, e.busy, e.clk, e.off, est_of(e.mode));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state, R9 run estimate
        push_n("R1_reset", 2'd0, 0, 1, 3'b000, 3); drain();

        // R2 run -> idle
        pulse(0, 2'd1);
        push_n("R2_enter_idle", 2'd0, 1, 1, 3'b000, TI_IN);
        push_n("R2_idle", 2'd1, 0, 0, 3'b000, 3); drain();

        // R6 sleep request in idle ignored; R10 code 0/3 ignored
        pulse(0, 2'd2); push_n("R6_sleep_in_idle", 2'd1, 0, 0, 3'b000, 3); drain();
        pulse(0, 2'd3); push_n("R10_code3_idle", 2'd1, 0, 0, 3'b000, 2); drain();
        // R8 wake event in idle ignored
        pulse(2, 2'd0); push_n("R8_wake_in_idle", 2'd1, 0, 0, 3'b000, 3); drain();

        // R3 idle -> run on interrupt
        pulse(1, 2'd0);
        push_n("R3_exit_idle", 2'd1, 1, 0, 3'b000, TI_OUT);
        push_n("R3_run", 2'd0, 0, 1, 3'b000, 3); drain();

        // R10 codes 0 and 3 in run; R8 irq and wake in run
        pulse(0, 2'd0); push_n("R10_code0_run", 2'd0, 0, 1, 3'b000, 2); drain();
        pulse(0, 2'd3); push_n("R10_code3_run", 2'd0, 0, 1, 3'b000, 2); drain();
        pulse(1, 2'd0); push_n("R8_irq_in_run", 2'd0, 0, 1, 3'b000, 2); drain();
        pulse(2, 2'd0); push_n("R8_wake_in_run", 2'd0, 0, 1, 3'b000, 2); drain();

        // R4 sleep entry, R7 request mid-entry ignored
        pulse(0, 2'd2);
        push_n("R4_step0", 2'd0, 1, 0, 3'b001, TSTEP);
        push_n("R4_step1", 2'd0, 1, 0, 3'b011, TSTEP);
        push_n("R4_step2", 2'd0, 1, 0, 3'b111, TSTEP);
        push_n("R4_sleep", 2'd2, 0, 0, 3'b111, 3);
        pulse(0, 2'd1);  // R7
        drain();

        // R8 irq in sleep ignored; R7-style idle request in sleep also ignored
        pulse(1, 2'd0); push_n("R8_irq_in_sleep", 2'd2, 0, 0, 3'b111, 3); drain();
        pulse(0, 2'd1); push_n("R6_idle_req_in_sleep", 2'd2, 0, 0, 3'b111, 3); drain();

        // R5 wake sequence, R7 request and irq mid-wake ignored
        pulse(2, 2'd0);
        push_n("R5_release2", 2'd2, 1, 0, 3'b011, TRLS);
        push_n("R5_release1", 2'd2, 1, 0, 3'b001, TRLS);
        push_n("R5_release0", 2'd2, 1, 0, 3'b000, TRLS);
        push_n("R5_settle", 2'd2, 1, 0, 3'b000, TWAKE);
        push_n("R5_run", 2'd0, 0, 1, 3'b000, 3);
        pulse(0, 2'd2);  // R7
        pulse(1, 2'd0);  // R7
        drain();

        // R7 request during idle entry ignored
        pulse(0, 2'd1);
        push_n("R7_enter_idle", 2'd0, 1, 1, 3'b000, TI_IN);
        push_n("R7_idle", 2'd1, 0, 0, 3'b000, 2);
        pulse(0, 2'd2);
        drain();
        pulse(1, 2'd0);
        push_n("R3_exit2", 2'd1, 1, 0, 3'b000, TI_OUT);
        push_n("R3_run2", 2'd0, 0, 1, 3'b000, 2); drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule